// File: doc/BRIEF.md
# Double-Operand Funnel Shift Unit

This unit performs the 64-bit double-precision shifts of an integer execution pipe. A destination operand moves left or right by a count, and the bit positions that open up are filled from a second source operand rather than with zeros. The count comes either from a count register or from an immediate, and only its low six bits are used. A masked count of zero leaves the destination and every flag untouched.

Alongside the shifted value the unit produces a write-enable and a new set of carry, parity, auxiliary, zero, sign and overflow flags. Operations enter through a valid/ready handshake, one per cycle. Every output is registered, so a result appears one cycle after its operation is accepted. Decode and operand fetch happen upstream. Writeback of the result and flags happens downstream, under control of the write-enable.

Top module: `funnel_shift_unit`

## Requirements
- R1: The effective count n is the low 6 bits of `cnt_imm` when `cnt_sel_imm` is 1, and of `cnt_reg` when it is 0, so n is 0 to 63 and higher count bits are ignored.
- R2: When n is 0, `wr_en` is 0, `result` equals the incoming `dst_in` and `flags_out` equals the incoming `flags_in`.
- R3: With `dir_right` = 0 and n nonzero, `result` is `dst_in` shifted left by n with its low n bits taken from the top n bits of `src_in`.
- R4: With `dir_right` = 0 and n nonzero, carry (flag bit 0) is bit 64-n of `dst_in`, and overflow (flag bit 5) is carry XOR `result` bit 63.
- R5: With `dir_right` = 1 and n nonzero, `result` is `dst_in` shifted right by n with its top n bits taken from the low n bits of `src_in`.
- R6: With `dir_right` = 1 and n nonzero, carry is bit n-1 of `dst_in`, and overflow is `result` bit 63 XOR `result` bit 62.
- R7: For n nonzero, `wr_en` is 1 and the other flags are set as follows. Sign (bit 4) is `result` bit 63. Zero (bit 3) is 1 exactly when `result` is all zeros. Parity (bit 2) is 1 when `result[7:0]` holds an even number of ones. Auxiliary (bit 1) is 0.
- R8: `out_valid` is 1 in the cycle after an accepted operation (`in_valid` and `in_ready` both 1) and 0 otherwise. When no operation is accepted, `result`, `wr_en` and `flags_out` hold their values.
- R9: During reset, `out_valid`, `wr_en`, `result` and `flags_out` are 0 and `in_ready` is 0. `in_ready` becomes 1 at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| dir_right | input | 1 | 1 selects a right shift, 0 a left shift |
| cnt_sel_imm | input | 1 | 1 takes the count from the immediate |
| cnt_reg | input | 8 | Count register value |
| cnt_imm | input | 8 | Immediate count |
| dst_in | input | 64 | Destination operand |
| src_in | input | 64 | Fill source operand |
| flags_in | input | 6 | Current flags {OF,SF,ZF,PF,AF,CF} |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Shifted value |
| wr_en | output | 1 | Destination and flags are to be written |
| flags_out | output | 6 | Updated flags, same layout as flags_in |

## Verification
The assertions assume that `in_valid`, the operands, the count fields and `flags_in` are stable and free of X at each rising edge. They also assume that reset is held long enough for one edge to clear the registers. The bench meets these assumptions by changing inputs only on falling edges and by holding reset low for several cycles. It draws every field from `$urandom` with a fixed seed, covering both count sources and count values above 63. It then adds directed operations for counts 0, 1 and 63, a masked-to-zero count, and an all-zero result.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
   // flag vector layout shared by flags_in and flags_out
   localparam int FLAG_W  = 6;
   localparam int FLG_CF  = 0;
   localparam int FLG_AF  = 1;
   localparam int FLG_PF  = 2;
   localparam int FLG_ZF  = 3;
   localparam int FLG_SF  = 4;
   localparam int FLG_OF  = 5;

   typedef enum logic [0:0] {
      SHIFT_BEHAV  = 1'b0,
      SHIFT_BARREL = 1'b1
   } shift_impl_e;
endpackage

// File: rtl/fsu_count.sv
module fsu_count #(
   parameter int CREG_W = 8,
   parameter int IMM_W  = 8,
   parameter int CNT_W  = 6
) (
   input  logic              sel_imm,
   input  logic [CREG_W-1:0] creg,
   input  logic [IMM_W-1:0]  cimm,
   output logic [CNT_W-1:0]  cnt,
   output logic              cnt_nz
);
   generate
      if (CREG_W < CNT_W) begin : g_bad_creg
         $error("fsu_count: CREG_W narrower than CNT_W");
      end
      if (IMM_W < CNT_W) begin : g_bad_imm
         $error("fsu_count: IMM_W narrower than CNT_W");
      end
   endgenerate

   // only the low CNT_W bits of either source matter
   always_comb begin
      if (sel_imm) cnt = cimm[CNT_W-1:0];
      else         cnt = creg[CNT_W-1:0];
      cnt_nz = |cnt;
   end
endmodule

// File: rtl/fsu_funnel.sv
module fsu_funnel #(
   parameter int                  DATA_W = 64,
   parameter int                  CNT_W  = 6,
   parameter fsu_pkg::shift_impl_e IMPL  = fsu_pkg::SHIFT_BARREL
) (
   input  logic              dir_right,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   localparam int WIDE_W = 2 * DATA_W + 1;

   // left window: {guard, dst, src}; the guard catches the last bit out
   // right window: {src, dst, guard}; the guard catches the last bit out
   logic [WIDE_W-1:0] left_in, right_in;
   logic [WIDE_W-1:0] left_out, right_out;

   assign left_in  = {1'b0, dst, src};
   assign right_in = {src, dst, 1'b0};

   generate
      if (IMPL == fsu_pkg::SHIFT_BEHAV) begin : g_behav
         assign left_out  = left_in << cnt;
         assign right_out = right_in >> cnt;
      end else begin : g_barrel
         logic [WIDE_W-1:0] lstg [0:CNT_W];
         logic [WIDE_W-1:0] rstg [0:CNT_W];
         assign lstg[0] = left_in;
         assign rstg[0] = right_in;
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            assign lstg[k+1] = cnt[k] ? (lstg[k] << (1 << k)) : lstg[k];
            assign rstg[k+1] = cnt[k] ? (rstg[k] >> (1 << k)) : rstg[k];
         end
         assign left_out  = lstg[CNT_W];
         assign right_out = rstg[CNT_W];
      end
   endgenerate

   always_comb begin
      if (dir_right) begin
         res  = right_out[DATA_W:1];
         cout = right_out[0];
      end else begin
         res  = left_out[2*DATA_W-1:DATA_W];
         cout = left_out[2*DATA_W];
      end
   end
endmodule

// File: rtl/fsu_flags.sv
module fsu_flags #(
   parameter int DATA_W = 64,
   parameter int PAR_W  = 8
) (
   input  logic                       dir_right,
   input  logic [DATA_W-1:0]          res,
   input  logic                       cout,
   output logic [fsu_pkg::FLAG_W-1:0] flags
);
   import fsu_pkg::*;

   generate
      if (PAR_W > DATA_W) begin : g_bad_par
         $error("fsu_flags: PAR_W exceeds DATA_W");
      end
   endgenerate

   always_comb begin
      flags         = '0;
      flags[FLG_CF] = cout;
      flags[FLG_AF] = 1'b0;
      flags[FLG_PF] = ~^res[PAR_W-1:0];
      flags[FLG_ZF] = (res == '0);
      flags[FLG_SF] = res[DATA_W-1];
      if (dir_right) flags[FLG_OF] = res[DATA_W-1] ^ res[DATA_W-2];
      else           flags[FLG_OF] = res[DATA_W-1] ^ cout;
   end
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
   parameter int                   DATA_W = 64,
   parameter int                   CREG_W = 8,
   parameter int                   IMM_W  = 8,
   parameter int                   PAR_W  = 8,
   parameter fsu_pkg::shift_impl_e IMPL   = fsu_pkg::SHIFT_BARREL
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic                       dir_right,
   input  logic                       cnt_sel_imm,
   input  logic [CREG_W-1:0]          cnt_reg,
   input  logic [IMM_W-1:0]           cnt_imm,
   input  logic [DATA_W-1:0]          dst_in,
   input  logic [DATA_W-1:0]          src_in,
   input  logic [fsu_pkg::FLAG_W-1:0] flags_in,
   output logic                       out_valid,
   output logic [DATA_W-1:0]          result,
   output logic                       wr_en,
   output logic [fsu_pkg::FLAG_W-1:0] flags_out
);
   import fsu_pkg::*;

   localparam int CNT_W = $clog2(DATA_W);

   generate
      if ((1 << CNT_W) != DATA_W) begin : g_bad_pow2
         $error("funnel_shift_unit: DATA_W must be a power of two");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("funnel_shift_unit: DATA_W below 8");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic              cnt_nz;
   logic [DATA_W-1:0] sh_res;
   logic              sh_cout;
   logic [FLAG_W-1:0] new_flags;
   logic              ready_q;
   logic              accept;

   fsu_count #(.CREG_W(CREG_W), .IMM_W(IMM_W), .CNT_W(CNT_W)) u_count (
      .sel_imm (cnt_sel_imm),
      .creg    (cnt_reg),
      .cimm    (cnt_imm),
      .cnt     (cnt),
      .cnt_nz  (cnt_nz)
   );

   fsu_funnel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMPL(IMPL)) u_funnel (
      .dir_right (dir_right),
      .dst       (dst_in),
      .src       (src_in),
      .cnt       (cnt),
      .res       (sh_res),
      .cout      (sh_cout)
   );

   fsu_flags #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_flags (
      .dir_right (dir_right),
      .res       (sh_res),
      .cout      (sh_cout),
      .flags     (new_flags)
   );

   assign in_ready = ready_q;
   assign accept   = in_valid & ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q   <= 1'b0;
         out_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         flags_out <= '0;
      end else begin
         ready_q   <= 1'b1;
         out_valid <= accept;
         if (accept) begin
            wr_en <= cnt_nz;
            if (cnt_nz) begin
               result    <= sh_res;
               flags_out <= new_flags;
            end else begin
               result    <= dst_in;
               flags_out <= flags_in;
            end
         end
      end
   end
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker #(
   parameter int DATA_W = 64,
   parameter int CREG_W = 8,
   parameter int IMM_W  = 8,
   parameter int PAR_W  = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic                       in_ready,
   input logic                       dir_right,
   input logic                       cnt_sel_imm,
   input logic [CREG_W-1:0]          cnt_reg,
   input logic [IMM_W-1:0]           cnt_imm,
   input logic [DATA_W-1:0]          dst_in,
   input logic [fsu_pkg::FLAG_W-1:0] flags_in,
   input logic                       out_valid,
   input logic [DATA_W-1:0]          result,
   input logic                       wr_en,
   input logic [fsu_pkg::FLAG_W-1:0] flags_out
);
   import fsu_pkg::*;

   localparam int CNT_W = $clog2(DATA_W);

   logic acc;
   logic zero_cnt;
   assign acc      = in_valid && in_ready;
   assign zero_cnt = cnt_sel_imm ? (cnt_imm[CNT_W-1:0] == '0)
                                 : (cnt_reg[CNT_W-1:0] == '0);

   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);
   assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !out_valid && $stable(result) && $stable(flags_out) && $stable(wr_en));
   assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && zero_cnt) |=> (!wr_en && result == $past(dst_in) && flags_out == $past(flags_in)));
   assert_nonzero_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !zero_cnt) |=> wr_en);
   assert_aux_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wr_en) |-> !flags_out[FLG_AF]);
   assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wr_en) |-> flags_out[FLG_PF] == ~^result[PAR_W-1:0]);
   assert_right_of_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !zero_cnt && dir_right) |=>
         flags_out[FLG_OF] == (result[DATA_W-1] ^ result[DATA_W-2]));
   assert_left_of_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !zero_cnt && !dir_right) |=>
         flags_out[FLG_OF] == (flags_out[FLG_CF] ^ result[DATA_W-1]));
   assert_reset_ready_R9: assert property (@(posedge clk)
      !rst_n |=> (!in_ready && !out_valid && !wr_en));
endmodule

bind funnel_shift_unit fsu_checker #(
   .DATA_W(DATA_W), .CREG_W(CREG_W), .IMM_W(IMM_W), .PAR_W(PAR_W)
) u_fsu_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .dir_right   (dir_right),
   .cnt_sel_imm (cnt_sel_imm),
   .cnt_reg     (cnt_reg),
   .cnt_imm     (cnt_imm),
   .dst_in      (dst_in),
   .flags_in    (flags_in),
   .out_valid   (out_valid),
   .result      (result),
   .wr_en       (wr_en),
   .flags_out   (flags_out)
);

// File: tb/funnel_shift_unit_test.sv
module funnel_shift_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int N_RANDOM   = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        dir_right = 1'b0;
   logic        cnt_sel_imm = 1'b0;
   logic [7:0]  cnt_reg = '0;
   logic [7:0]  cnt_imm = '0;
   logic [63:0] dst_in = '0;
   logic [63:0] src_in = '0;
   logic [5:0]  flags_in = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        wr_en;
   logic [5:0]  flags_out;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 0;

   funnel_shift_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .dir_right(dir_right), .cnt_sel_imm(cnt_sel_imm), .cnt_reg(cnt_reg),
      .cnt_imm(cnt_imm), .dst_in(dst_in), .src_in(src_in), .flags_in(flags_in),
      .out_valid(out_valid), .result(result), .wr_en(wr_en), .flags_out(flags_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog R8: actual %0d cycles expected below %0d", cycles, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // expected result, built bit by bit from the requirement text
   function automatic logic [63:0] ref_result(bit right, int n, logic [63:0] d, logic [63:0] s);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) begin
         if (right) r[i] = (i + n < 64) ? d[i+n] : s[i+n-64];
         else       r[i] = (i - n >= 0) ? d[i-n] : s[64+i-n];
      end
      return r;
   endfunction

   function automatic logic [5:0] ref_flags(bit right, int n, logic [63:0] d, logic [63:0] r);
      logic [5:0] f;
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += r[i];
      f[0] = right ? d[n-1] : d[64-n];
      f[1] = 1'b0;
      f[2] = (ones % 2 == 0);
      f[3] = (r == 64'd0);
      f[4] = r[63];
      f[5] = right ? (r[63] ^ r[62]) : (f[0] ^ r[63]);
      return f;
   endfunction

   // drive at a falling edge, check one full cycle later
   task automatic do_op(input bit right, input bit imm, input logic [7:0] creg,
                        input logic [7:0] cimm, input logic [63:0] d,
                        input logic [63:0] s, input logic [5:0] fin);
      int n;
      logic [63:0] er;
      logic [5:0]  ef;
      in_valid = 1'b1; dir_right = right; cnt_sel_imm = imm;
      cnt_reg = creg; cnt_imm = cimm; dst_in = d; src_in = s; flags_in = fin;
      n = imm ? int'(cimm[5:0]) : int'(creg[5:0]);   // R1 masking
      @(negedge clk);
      check(out_valid === 1'b1, "R8 out_valid after accept", {63'd0, out_valid}, 64'd1);
      if (n == 0) begin
         check(wr_en === 1'b0, "R2 wr_en on zero count", {63'd0, wr_en}, 64'd0);
         check(result === d, "R2 result on zero count", result, d);
         check(flags_out === fin, "R2 flags on zero count", {58'd0, flags_out}, {58'd0, fin});
      end else begin
         er = ref_result(right, n, d, s);
         ef = ref_flags(right, n, d, er);
         check(wr_en === 1'b1, "R7 wr_en on nonzero count", {63'd0, wr_en}, 64'd1);
         check(result === er, right ? "R5 right result (R1 count)" : "R3 left result (R1 count)", result, er);
         check(flags_out[5] === ef[5] && flags_out[0] === ef[0],
               right ? "R6 right carry/overflow" : "R4 left carry/overflow",
               {58'd0, flags_out}, {58'd0, ef});
         check(flags_out[4:1] === ef[4:1], "R7 sign/zero/parity/aux",
               {58'd0, flags_out}, {58'd0, ef});
      end
   endtask

   task automatic go_idle();
      logic [63:0] held_r;
      logic [5:0]  held_f;
      held_r = result; held_f = flags_out;
      in_valid = 1'b0;
      dst_in = ~dst_in; flags_in = ~flags_in; cnt_reg = 8'h05;
      @(negedge clk);
      check(out_valid === 1'b0, "R8 out_valid low when idle", {63'd0, out_valid}, 64'd0);
      check(result === held_r && flags_out === held_f, "R8 outputs held when idle", result, held_r);
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
      repeat (4) @(negedge clk);
      // R9 reset state
      check(in_ready === 1'b0, "R9 in_ready in reset", {63'd0, in_ready}, 64'd0);
      check(out_valid === 1'b0 && wr_en === 1'b0, "R9 valid/wr_en in reset", {62'd0, out_valid, wr_en}, 64'd0);
      check(result === 64'd0 && flags_out === 6'd0, "R9 result/flags in reset", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready === 1'b1, "R9 in_ready after reset", {63'd0, in_ready}, 64'd1);

      // directed corners
      do_op(0, 0, 8'h40, 8'h00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 6'b101011); // R1 masked to 0, R2
      do_op(1, 1, 8'h07, 8'hC0, 64'hDEAD_BEEF_0000_0001, 64'h1, 6'b010101);                  // R1 imm masked to 0
      do_op(0, 0, 8'h01, 8'h00, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 6'd0);     // R3 R4 n=1
      do_op(1, 0, 8'h01, 8'h00, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0001, 6'd0);     // R5 R6 n=1
      do_op(0, 1, 8'h00, 8'hFF, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFE, 6'd0);     // R1 imm 63 left
      do_op(1, 0, 8'hBF, 8'h00, 64'h8000_0000_0000_0000, 64'h5555_5555_5555_5555, 6'd0);     // R1 reg 63 right
      do_op(0, 0, 8'h05, 8'h00, 64'd0, 64'd0, 6'b111111);                                    // R7 zero result
      go_idle();

      // random, back to back
      for (int k = 0; k < N_RANDOM; k++) begin
         do_op($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom), 8'($urandom),
               {$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom));
         if ((k % 50) == 49) go_idle();
      end
      go_idle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule